// File: doc/BRIEF.md
# Flash Region Access-Control Checker

This block sits in front of an on-chip flash controller and decides, request by request, whether an access may proceed. It holds a bank of protection regions. Each region is described by a start address, a length in bytes and two permission bits. Software programs these registers once during boot through a simple word-addressed register port. After that they stay fixed until the next reset.

Every flash request arrives with its address and a type code. The block checks it against every armed region and answers allow or deny in the same cycle. When it denies, it raises a one-cycle fault pulse on the following cycle.

Each region carries a small sequencer with five states:
- `RG_CFG`: the region is collecting its three registers.
- `RG_DLY1` and `RG_DLY2`: two settling cycles.
- `RG_LIVE`: the region is enforced.
- `RG_DEAD`: the configuration was complete but malformed, so the region is never enforced.

The transitions between these states are:
- `RG_CFG -> RG_DLY1` on the edge that completes the third register.
- `RG_DLY1 -> RG_DLY2` unconditionally.
- `RG_DLY2 -> RG_LIVE` when the configuration is well formed.
- `RG_DLY2 -> RG_DEAD` otherwise.
- `RG_LIVE` and `RG_DEAD` hold until reset.

A debug-bypass bit disables all checking while the debug link is active.

Top module: `flash_guard`

## Requirements
- R1: After reset, every region register reads 0, the debug-bypass register (offset 0x704, bit 0) reads 1, and no request is denied.
- R2: The start-address, size and permission registers of a region each accept only their first effective write. Later writes, including a write of the same value, leave the stored value unchanged.
- R3: Writing 0 to a size register, or a permission value with both bits 0, has no effect. The write is not stored and does not count toward arming the region.
- R4: Permission bit 0 set blocks write (type 1), erase (type 2) and reserved (type 3) requests. Permission bit 1 set blocks read/fetch (type 0) requests. With both bits set, every type is blocked.
- R5: A region is never enforced unless its start address is a multiple of PAGE_BYTES and its size is a nonzero multiple of PAGE_BYTES.
- R6: A region denies requests from the second clock edge after the edge that completed its last register write. Requests in the two cycles before that are allowed.
- R7: A request hits a region when start <= address < start + size. Addresses below start or at start + size are outside the region.
- R8: When regions overlap, a request is denied if any live region it hits forbids its type.
- R9: `req_deny` and `req_allow` are combinational in the request cycle and are never both 1. `fault_pulse` is 1 for exactly the cycle after each denied request.
- R10: While bypass bit 0 is 1 and `dbg_active` is 1, no request is denied. Software may clear the bit, after which checking applies during debug as well.
- R11: Region n has its start address at offset 0x800+16n, its size at 0x804+16n and its permissions at 0x808+16n. Offset 0x80C+16n reads 0. Permissions read back in bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset (word aligned) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| dbg_active | input | 1 | Debug link is active |
| req_valid | input | 1 | Flash request present |
| req_addr | input | 32 | Flash request byte address |
| req_type | input | 2 | 0 read/fetch, 1 write, 2 erase, 3 reserved |
| req_allow | output | 1 | Request may be forwarded to flash |
| req_deny | output | 1 | Request is blocked |
| fault_pulse | output | 1 | One-cycle fault strobe after a denial |

## Verification
The bench targets the arming window by probing a protected address in each of the three cycles after the final permission write. A design with one settling stage too few or too many would deny one cycle early or allow one cycle late.

It probes the first byte, the last word and the byte just past each region. An off-by-one comparator would misclassify one of these probes.

It rewrites locked registers and writes zeros, then reads the registers back. A design that latched the second write, or counted a zero size as written, would show a changed value or arm a region early.

Misaligned and non-page-multiple configurations must stay permissive. Overlapping regions with different permissions must combine, so a design that let the first match win would allow a forbidden write. The debug bypass is exercised in both settings of its bit.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    localparam int REG_AW = 12;
    typedef logic [REG_AW-1:0] reg_off_t;

    localparam reg_off_t DBG_OFF     = 12'h704;
    localparam reg_off_t REGION_BASE = 12'h800;
    localparam int       STRIDE      = 16;

    typedef enum logic [2:0] {
        RG_CFG  = 3'd0,
        RG_DLY1 = 3'd1,
        RG_DLY2 = 3'd2,
        RG_LIVE = 3'd3,
        RG_DEAD = 3'd4
    } rg_state_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_ERASE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_type_e;

endpackage

// File: rtl/fg_region.sv
module fg_region
    import flash_guard_pkg::*;
#(
    parameter int AW         = 32,
    parameter int PAGE_BYTES = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_base,
    input  logic          wr_size,
    input  logic          wr_perm,
    input  logic [AW-1:0] wdata,
    input  logic [AW-1:0] req_addr,
    input  logic          req_is_read,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] size_q,
    output logic [1:0]    perm_q,
    output logic          forbid
);
    localparam int PAGE_BITS = $clog2(PAGE_BYTES);

    logic base_done, size_done, perm_done;
    logic take_base, take_size, take_perm;
    logic all_next, cfg_ok, hit, live;
    logic [AW:0] end_x;
    rg_state_e st, st_nx;

    assign take_base = wr_base && !base_done;
    assign take_size = wr_size && !size_done && (wdata != '0);
    assign take_perm = wr_perm && !perm_done && (wdata[1:0] != 2'b00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q    <= '0;
            size_q    <= '0;
            perm_q    <= '0;
            base_done <= 1'b0;
            size_done <= 1'b0;
            perm_done <= 1'b0;
        end else begin
            if (take_base) begin
                base_q    <= wdata;
                base_done <= 1'b1;
            end
            if (take_size) begin
                size_q    <= wdata;
                size_done <= 1'b1;
            end
            if (take_perm) begin
                perm_q    <= wdata[1:0];
                perm_done <= 1'b1;
            end
        end
    end

    assign all_next = (base_done || take_base) && (size_done || take_size) &&
                      (perm_done || take_perm);
    assign cfg_ok   = (base_q[PAGE_BITS-1:0] == '0) && (size_q[PAGE_BITS-1:0] == '0) &&
                      (size_q != '0) && (perm_q != 2'b00);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RG_CFG;
        else        st <= st_nx;
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            RG_CFG:  if (all_next) st_nx = RG_DLY1;
            RG_DLY1: st_nx = RG_DLY2;
            RG_DLY2: st_nx = cfg_ok ? RG_LIVE : RG_DEAD;
            RG_LIVE: st_nx = RG_LIVE;
            RG_DEAD: st_nx = RG_DEAD;
            default: st_nx = RG_CFG;
        endcase
    end

    // outputs
    assign end_x = {1'b0, base_q} + {1'b0, size_q};
    assign hit   = (req_addr >= base_q) && ({1'b0, req_addr} < end_x);

    always_comb begin
        live   = (st == RG_LIVE);
        forbid = live && hit && (req_is_read ? perm_q[1] : perm_q[0]);
    end

    a_r2_base_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        base_done |=> $stable(base_q));
    a_r2_perm_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        perm_done |=> $stable(perm_q) && perm_done);
    a_r6_settle_chain: assert property (@(posedge clk) disable iff (!rst_n)
        st == RG_DLY1 |=> st == RG_DLY2);
    a_r5_live_wellformed: assert property (@(posedge clk) disable iff (!rst_n)
        st == RG_LIVE |-> size_q != '0 && base_q[PAGE_BITS-1:0] == '0);

endmodule

// File: rtl/fg_combine.sv
module fg_combine #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] forbid_vec,
    input  logic         req_valid,
    input  logic         bypass,
    output logic         req_allow,
    output logic         req_deny,
    output logic         fault_pulse
);
    always_comb begin
        req_deny  = req_valid && !bypass && (|forbid_vec);
        req_allow = req_valid && !req_deny;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_pulse <= 1'b0;
        else        fault_pulse <= req_deny;
    end

    a_r9_fault_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_deny |=> fault_pulse);
    a_r9_fault_single: assert property (@(posedge clk) disable iff (!rst_n)
        !req_deny |=> !fault_pulse);
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_deny && req_allow));
    a_r10_bypass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> !req_deny);

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int N_REGIONS  = 8,
    parameter int AW         = 32,
    parameter int PAGE_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [AW-1:0]     reg_wdata,
    output logic [AW-1:0]     reg_rdata,
    input  logic              dbg_active,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_type,
    output logic              req_allow,
    output logic              req_deny,
    output logic              fault_pulse
);
    logic [AW-1:0]        base_w [N_REGIONS];
    logic [AW-1:0]        size_w [N_REGIONS];
    logic [1:0]           perm_w [N_REGIONS];
    logic [N_REGIONS-1:0] forbid_w;
    logic                 dbg_bypass_q;
    logic                 req_is_read;

    assign req_is_read = (acc_type_e'(req_type) == ACC_READ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            dbg_bypass_q <= 1'b1;
        else if (reg_we && reg_addr == DBG_OFF) dbg_bypass_q <= reg_wdata[0];
    end

    for (genvar g = 0; g < N_REGIONS; g++) begin : g_region
        localparam reg_off_t OFF = reg_off_t'(int'(REGION_BASE) + STRIDE * g);
        fg_region #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_region (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_base    (reg_we && reg_addr == OFF),
            .wr_size    (reg_we && reg_addr == OFF + reg_off_t'(4)),
            .wr_perm    (reg_we && reg_addr == OFF + reg_off_t'(8)),
            .wdata      (reg_wdata),
            .req_addr   (req_addr),
            .req_is_read(req_is_read),
            .base_q     (base_w[g]),
            .size_q     (size_w[g]),
            .perm_q     (perm_w[g]),
            .forbid     (forbid_w[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == DBG_OFF) reg_rdata = AW'(dbg_bypass_q);
        for (int i = 0; i < N_REGIONS; i++) begin
            if (reg_addr == reg_off_t'(int'(REGION_BASE) + STRIDE * i))     reg_rdata = base_w[i];
            if (reg_addr == reg_off_t'(int'(REGION_BASE) + STRIDE * i + 4)) reg_rdata = size_w[i];
            if (reg_addr == reg_off_t'(int'(REGION_BASE) + STRIDE * i + 8)) reg_rdata = AW'(perm_w[i]);
        end
    end

    fg_combine #(.N(N_REGIONS)) u_combine (
        .clk        (clk),
        .rst_n      (rst_n),
        .forbid_vec (forbid_w),
        .req_valid  (req_valid),
        .bypass     (dbg_bypass_q && dbg_active),
        .req_allow  (req_allow),
        .req_deny   (req_deny),
        .fault_pulse(fault_pulse)
    );

    a_r1_no_deny_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !req_deny);

endmodule

// File: tb/flash_guard_tb.sv
module flash_guard_tb;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dbg_active = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_type = '0;
    logic        req_allow, req_deny, fault_pulse;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    bit prev_deny = 0;

    typedef struct {
        logic  valid;
        logic  deny;
        logic  fault;
        string tag;
    } exp_t;
    exp_t sb_q[$];
    event ev_sample;

    always #(PERIOD/2) clk = ~clk;

    flash_guard u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_active(dbg_active),
        .req_valid(req_valid), .req_addr(req_addr), .req_type(req_type),
        .req_allow(req_allow), .req_deny(req_deny), .fault_pulse(fault_pulse)
    );

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b0;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
        prev_deny = 0;
    endtask

    task automatic reg_check(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b0;
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s: reg 0x%0h got 0x%0h expected 0x%0h", tag, a, reg_rdata, exp);
        end
        prev_deny = 0;
    endtask

    // driver: one request per cycle, expected item pushed to the scoreboard
    task automatic req_check(input logic v, input logic [31:0] a, input logic [1:0] t,
                             input logic exp_deny, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = v; req_addr = a; req_type = t;
        e.valid = v; e.deny = exp_deny; e.fault = prev_deny; e.tag = tag;
        sb_q.push_back(e);
        prev_deny = exp_deny;
        #(PERIOD/4);
        -> ev_sample;
        #1;
    endtask

    // monitor
    initial begin
        forever begin
            exp_t e;
            @(ev_sample);
            e = sb_q.pop_front();
            checks++;
            if (req_deny !== e.deny || req_allow !== (e.valid && !e.deny) ||
                fault_pulse !== e.fault) begin
                errors++;
                $display("FAIL %s: deny=%b allow=%b fault=%b expected deny=%b allow=%b fault=%b",
                         e.tag, req_deny, req_allow, fault_pulse,
                         e.deny, e.valid && !e.deny, e.fault);
            end
        end
    end

    initial begin
        #(PERIOD * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        reg_check(12'h704, 32'h1, "R1 bypass reset");
        reg_check(12'h800, 32'h0, "R1 base reset");
        reg_check(12'h808, 32'h0, "R1 perm reset");
        req_check(1, 32'h0000_1000, 2'd1, 0, "R1 no deny after reset");

        // region 0: 0x1000..0x2FFF, block write/erase
        reg_write(12'h800, 32'h0000_1000);
        reg_write(12'h804, 32'h0);
        reg_check(12'h804, 32'h0, "R3 zero size ignored");
        reg_write(12'h804, 32'h0000_2000);
        reg_write(12'h808, 32'h0);
        reg_check(12'h808, 32'h0, "R3 zero perm ignored");
        req_check(1, 32'h0000_1000, 2'd1, 0, "R3 zero perm does not arm");
        reg_write(12'h808, 32'h1);
        req_check(1, 32'h0000_1000, 2'd1, 0, "R6 first cycle after arm allowed");
        req_check(1, 32'h0000_1000, 2'd1, 0, "R6 second cycle after arm allowed");
        req_check(1, 32'h0000_1000, 2'd1, 1, "R6 enforced from second edge");
        req_check(0, 32'h0, 2'd0, 0, "R9 fault pulse after deny");
        req_check(0, 32'h0, 2'd0, 0, "R9 fault single cycle");

        // R2 write-once
        reg_write(12'h800, 32'h0000_5000);
        reg_check(12'h800, 32'h0000_1000, "R2 base locked");
        reg_write(12'h808, 32'h3);
        reg_check(12'h808, 32'h1, "R2 perm locked");
        reg_write(12'h804, 32'h0000_2000);
        reg_check(12'h804, 32'h0000_2000, "R2 same-value rewrite");

        // R4 / R7
        req_check(1, 32'h0000_1800, 2'd0, 0, "R4 read allowed with write-block");
        req_check(1, 32'h0000_1FFC, 2'd2, 1, "R4 erase blocked");
        req_check(1, 32'h0000_0FFC, 2'd1, 0, "R7 below start");
        req_check(1, 32'h0000_2FFC, 2'd1, 1, "R7 last word inside");
        req_check(1, 32'h0000_3000, 2'd1, 0, "R7 end exclusive");

        // region 1: 0x2000..0x2FFF, block read; overlaps region 0
        reg_write(12'h810, 32'h0000_2000);
        reg_write(12'h814, 32'h0000_1000);
        reg_write(12'h818, 32'h2);
        req_check(0, 32'h0, 2'd0, 0, "R6 settle idle");
        req_check(0, 32'h0, 2'd0, 0, "R6 settle idle");
        req_check(1, 32'h0000_2800, 2'd0, 1, "R8 read blocked by region 1");
        req_check(1, 32'h0000_2800, 2'd1, 1, "R8 write blocked by region 0");
        req_check(1, 32'h0000_1800, 2'd0, 0, "R8 read outside region 1");

        // R5 malformed regions
        reg_write(12'h820, 32'h0000_8010);
        reg_write(12'h824, 32'h0000_1000);
        reg_write(12'h828, 32'h3);
        reg_write(12'h830, 32'h0000_9000);
        reg_write(12'h834, 32'h0000_1800);
        reg_write(12'h838, 32'h3);
        req_check(0, 32'h0, 2'd0, 0, "R5 settle idle");
        req_check(0, 32'h0, 2'd0, 0, "R5 settle idle");
        req_check(1, 32'h0000_8010, 2'd0, 0, "R5 misaligned base not enforced");
        req_check(1, 32'h0000_9000, 2'd1, 0, "R5 partial-page size not enforced");

        // region 4: fully locked
        reg_write(12'h840, 32'h0000_A000);
        reg_write(12'h844, 32'h0000_1000);
        reg_write(12'h848, 32'h3);
        req_check(0, 32'h0, 2'd0, 0, "R6 settle idle");
        req_check(0, 32'h0, 2'd0, 0, "R6 settle idle");
        req_check(1, 32'h0000_A000, 2'd0, 1, "R4 locked read");
        req_check(1, 32'h0000_A004, 2'd1, 1, "R4 locked write");
        req_check(1, 32'h0000_A008, 2'd3, 1, "R4 locked reserved type");
        reg_check(12'h848, 32'h3, "R11 perm readback");

        // R10 debug bypass
        dbg_active = 1'b1;
        req_check(1, 32'h0000_A000, 2'd1, 0, "R10 bypass in debug");
        req_check(1, 32'h0000_A000, 2'd0, 0, "R10 bypass no fault");
        reg_write(12'h704, 32'h0);
        reg_check(12'h704, 32'h0, "R10 bypass bit cleared");
        req_check(1, 32'h0000_A000, 2'd1, 1, "R10 enforced in debug when bit clear");
        dbg_active = 1'b0;

        // R11 map
        reg_check(12'h80C, 32'h0, "R11 reserved slot");
        reg_check(12'h870, 32'h0, "R11 region 7 base empty");
        reg_write(12'h870, 32'h0001_0000);
        reg_write(12'h874, 32'h0000_3000);
        reg_check(12'h870, 32'h0001_0000, "R11 region 7 base");
        reg_check(12'h874, 32'h0000_3000, "R11 region 7 size");
        reg_check(12'h878, 32'h0, "R11 region 7 perm unset");

        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule